// File: doc/BRIEF.md
# Streaming Packet Statistics Monitor

This block sits on the receive side of an Ethernet client path and observes a 64-bit packet stream. Each beat carries start and end markers, a count of unused trailing bytes and an upstream error flag. The block does not store or forward data. It classifies every finished packet as good or bad, accumulates the number of bytes received, and measures how many clock cycles a run of packets takes.

Software programs a target packet total and clears the counters. It then sends traffic and polls a completion flag. The flag rises when the number of finished packets reaches the target. At that moment the cycle measurement freezes, so software can divide the byte total by the frozen cycle count to get throughput. All registers are 32-bit words selected by a word index. A word index equals the byte offset divided by four.

Top module: `pkt_stat_monitor`

## Requirements
- R1: Word 0 (byte offset 0x00) is a read/write target packet total. It reads 0xFFFFFFFF after reset and returns the last value written there.
- R2: Word 1 (0x04) counts packets whose end beat (rx_valid=1, rx_eop=1) has rx_err=0. It advances by one for each such packet.
- R3: Word 2 (0x08) counts packets whose end beat has rx_err=1. It advances by one for each such packet.
- R4: Words 3 and 4 (0x0C low half, 0x10 high half) hold a 64-bit byte total. Each accepted beat without rx_eop adds 8, and rx_empty is ignored on that beat. Each accepted end beat adds 8 minus rx_empty.
- R5: A cycle with rx_valid=0 changes no packet or byte count, whatever the values of rx_sop, rx_eop, rx_err and rx_empty.
- R6: Words 5 and 6 (0x14 low, 0x18 high) hold a 64-bit cycle count. It stays 0 until the first accepted rx_sop after reset or clear. It then counts every cycle from that start beat up to and including the cycle whose end beat brings good plus bad to the target. After that it holds its value.
- R7: Bit 2 of word 7 (0x1C) is a read-only done flag. It reads 1 from the edge that registers the end beat that makes good plus bad equal the target. It stays 1 until a clear, and later packets are still counted.
- R8: A write to word 7 with bit 0 set clears the good, bad, byte and cycle counts, the started state and the done flag. The target is preserved. A beat accepted in the same cycle as the clear is not counted. Bits 0 and 1 of word 7 read 0.
- R9: Writes to words 1 to 6, and the non-clear bits of word 7, change no register.
- R10: After reset every count is 0 and the done flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Beat present on the stream |
| rx_sop | input | 1 | First beat of a packet |
| rx_eop | input | 1 | Last beat of a packet |
| rx_empty | input | EMPTY_W (3) | Unused bytes in the last beat |
| rx_err | input | 1 | Packet failed its CRC upstream (meaningful on the last beat) |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index |
| csr_wdata | input | CNT_W (32) | Register write data |
| csr_rdata | output | CNT_W (32) | Register read data for csr_addr (combinational) |

## Verification
The assertions take for granted that rx_empty stays below the beat width. Under that condition a single beat cannot add more than eight bytes. They also assume that at most one packet ends per beat, so each of the good and bad counts moves by at most one per cycle. The stimulus keeps to these limits. It always sends whole packets framed by start and end markers, and it puts out-of-range values on rx_empty only on beats that are not end beats, where the value must be ignored. Idle gaps deliberately drive the marker and error lines while rx_valid is low.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;

    // Register word indices; software sees byte offset = 4 * index
    typedef enum logic [2:0] {
        REG_TARGET  = 3'd0,
        REG_GOOD    = 3'd1,
        REG_BAD     = 3'd2,
        REG_BYTE_LO = 3'd3,
        REG_BYTE_HI = 3'd4,
        REG_CYC_LO  = 3'd5,
        REG_CYC_HI  = 3'd6,
        REG_CTRL    = 3'd7
    } reg_idx_e;

    localparam int unsigned CTRL_CLEAR_BIT = 0;
    localparam int unsigned CTRL_DONE_BIT  = 2;

endpackage

// File: rtl/pkt_stat_counters.sv
module pkt_stat_counters #(
    parameter int unsigned BEAT_BYTES = 8,
    parameter int unsigned CNT_W      = 32,
    localparam int unsigned EMPTY_W   = $clog2(BEAT_BYTES),
    localparam int unsigned WIDE_W    = 2 * CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic [CNT_W-1:0]   target_i,
    input  logic               valid_i,
    input  logic               sop_i,
    input  logic               eop_i,
    input  logic [EMPTY_W-1:0] empty_i,
    input  logic               err_i,
    output logic [CNT_W-1:0]   good_o,
    output logic [CNT_W-1:0]   bad_o,
    output logic [WIDE_W-1:0]  bytes_o,
    output logic [WIDE_W-1:0]  cyc_o,
    output logic               done_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  good;
        logic [CNT_W-1:0]  bad;
        logic [WIDE_W-1:0] bytes;
        logic [WIDE_W-1:0] cyc;
        logic              run;
        logic              done;
    } stat_t;

    stat_t             st_d, st_q;
    logic              start_now;
    logic              pkt_end;
    logic [WIDE_W-1:0] beat_bytes;
    logic [CNT_W-1:0]  total_d;

    always_comb begin
        st_d       = st_q;
        start_now  = valid_i && sop_i && !st_q.run;
        pkt_end    = valid_i && eop_i;
        beat_bytes = eop_i ? (WIDE_W'(BEAT_BYTES) - WIDE_W'(empty_i))
                           : WIDE_W'(BEAT_BYTES);
        total_d    = '0;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (valid_i) begin
                st_d.bytes = st_q.bytes + beat_bytes;
            end
            if (pkt_end) begin
                if (err_i) st_d.bad  = st_q.bad + 1'b1;
                else       st_d.good = st_q.good + 1'b1;
            end
            if (!st_q.done && (st_q.run || start_now)) begin
                st_d.cyc = st_q.cyc + 1'b1;
            end
            if (start_now) begin
                st_d.run = 1'b1;
            end
            total_d = st_d.good + st_d.bad;
            if (pkt_end && (total_d == target_i)) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign good_o  = st_q.good;
    assign bad_o   = st_q.bad;
    assign bytes_o = st_q.bytes;
    assign cyc_o   = st_q.cyc;
    assign done_o  = st_q.done;

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !clr_i |=> st_q.done);

    // R6
    cyc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !clr_i |=> $stable(st_q.cyc));

    // R6
    cyc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run && !(valid_i && sop_i) && !clr_i |=> st_q.cyc == '0);

    // R2
    good_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (st_q.good == $past(st_q.good)) || (st_q.good == $past(st_q.good) + 1'b1));

    // R3
    bad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (st_q.bad == $past(st_q.bad)) || (st_q.bad == $past(st_q.bad) + 1'b1));

    // R4
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (st_q.bytes - $past(st_q.bytes)) <= WIDE_W'(BEAT_BYTES));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i && !clr_i |=> $stable(st_q.good) && $stable(st_q.bad) && $stable(st_q.bytes));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> st_q.good == '0 && st_q.bad == '0 && st_q.bytes == '0
                  && st_q.cyc == '0 && !st_q.done);

endmodule

// File: rtl/pkt_stat_csr.sv
module pkt_stat_csr
    import pkt_stat_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned WIDE_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  good_i,
    input  logic [CNT_W-1:0]  bad_i,
    input  logic [WIDE_W-1:0] bytes_i,
    input  logic [WIDE_W-1:0] cyc_i,
    input  logic              done_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [CNT_W-1:0]  target_o,
    output logic              clr_o
);

    logic [CNT_W-1:0] target_d, target_q;
    logic             wr_target;

    always_comb begin
        target_d  = target_q;
        wr_target = wr_i && (reg_idx_e'(addr_i) == REG_TARGET);
        clr_o     = wr_i && (reg_idx_e'(addr_i) == REG_CTRL) && wdata_i[CTRL_CLEAR_BIT];
        if (wr_target) begin
            target_d = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) target_q <= '1;
        else        target_q <= target_d;
    end

    always_comb begin
        rdata_o = '0;
        case (reg_idx_e'(addr_i))
            REG_TARGET:  rdata_o = target_q;
            REG_GOOD:    rdata_o = good_i;
            REG_BAD:     rdata_o = bad_i;
            REG_BYTE_LO: rdata_o = bytes_i[CNT_W-1:0];
            REG_BYTE_HI: rdata_o = bytes_i[WIDE_W-1:CNT_W];
            REG_CYC_LO:  rdata_o = cyc_i[CNT_W-1:0];
            REG_CYC_HI:  rdata_o = cyc_i[WIDE_W-1:CNT_W];
            REG_CTRL:    rdata_o[CTRL_DONE_BIT] = done_i;
            default:     rdata_o = '0;
        endcase
    end

    assign target_o = target_q;

    // R1
    target_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_target |=> target_q == $past(wdata_i));

    // R9
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_target |=> $stable(target_q));

endmodule

// File: rtl/pkt_stat_monitor.sv
module pkt_stat_monitor #(
    parameter int unsigned BEAT_BYTES = 8,
    parameter int unsigned CNT_W      = 32,
    localparam int unsigned EMPTY_W   = $clog2(BEAT_BYTES),
    localparam int unsigned WIDE_W    = 2 * CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic               rx_sop,
    input  logic               rx_eop,
    input  logic [EMPTY_W-1:0] rx_empty,
    input  logic               rx_err,
    input  logic               csr_wr,
    input  logic [2:0]         csr_addr,
    input  logic [CNT_W-1:0]   csr_wdata,
    output logic [CNT_W-1:0]   csr_rdata
);

    logic              clr;
    logic [CNT_W-1:0]  target;
    logic [CNT_W-1:0]  good_cnt, bad_cnt;
    logic [WIDE_W-1:0] byte_cnt, cyc_cnt;
    logic              done;

    pkt_stat_csr #(.CNT_W(CNT_W)) i_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (csr_wr),
        .addr_i   (csr_addr),
        .wdata_i  (csr_wdata),
        .good_i   (good_cnt),
        .bad_i    (bad_cnt),
        .bytes_i  (byte_cnt),
        .cyc_i    (cyc_cnt),
        .done_i   (done),
        .rdata_o  (csr_rdata),
        .target_o (target),
        .clr_o    (clr)
    );

    pkt_stat_counters #(.BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W)) i_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .target_i (target),
        .valid_i  (rx_valid),
        .sop_i    (rx_sop),
        .eop_i    (rx_eop),
        .empty_i  (rx_empty),
        .err_i    (rx_err),
        .good_o   (good_cnt),
        .bad_o    (bad_cnt),
        .bytes_o  (byte_cnt),
        .cyc_o    (cyc_cnt),
        .done_o   (done)
    );

endmodule

// File: tb/test_pkt_stat_monitor.sv
`timescale 1ns/1ps
module test_pkt_stat_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, rx_err = 1'b0;
    logic [2:0]  rx_empty = '0;
    logic        csr_wr = 1'b0;
    logic [2:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int n_chk = 0;
    int n_err = 0;

    // reference model built from the requirements
    logic [31:0] m_target = 32'hFFFF_FFFF;
    logic [31:0] m_good = '0, m_bad = '0;
    logic [63:0] m_bytes = '0, m_cyc = '0;
    logic        m_run = 1'b0, m_done = 1'b0;

    always #2 clk = ~clk;

    pkt_stat_monitor i_pkt_stat_monitor (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_empty(rx_empty), .rx_err(rx_err),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata)
    );

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // one clock: drive at negedge, update model at posedge, release after
    task automatic step(input logic v, s, e, input logic [2:0] em, input logic er,
                        input logic w, input logic [2:0] a, input logic [31:0] wd);
        logic clr;
        @(negedge clk);
        rx_valid = v; rx_sop = s; rx_eop = e; rx_empty = em; rx_err = er;
        csr_wr = w; csr_addr = a; csr_wdata = wd;
        @(posedge clk);
        clr = w && (a == 3'd7) && wd[0];
        if (clr) begin
            m_good = '0; m_bad = '0; m_bytes = '0; m_cyc = '0; m_run = 1'b0; m_done = 1'b0;
        end else begin
            if (!m_done && (m_run || (v && s))) m_cyc = m_cyc + 64'd1;
            if (v && s) m_run = 1'b1;
            if (v) m_bytes = m_bytes + (e ? 64'd8 - 64'(em) : 64'd8);
            if (v && e) begin
                if (er) m_bad = m_bad + 32'd1;
                else    m_good = m_good + 32'd1;
                if (m_good + m_bad == m_target) m_done = 1'b1;
            end
        end
        if (w && a == 3'd0) m_target = wd;
        #1;
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_empty = '0; rx_err = 1'b0;
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        step(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, a, d);
    endtask

    task automatic send_pkt(input int len, input logic [2:0] em, input logic er);
        for (int b = 0; b < len; b++)
            step(1'b1, b == 0, b == len - 1, (b == len - 1) ? em : 3'd5,
                 (b == len - 1) ? er : 1'b1, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        csr_addr = a;
        #0.1;
        n_chk++;
        if (csr_rdata !== exp) begin
            n_err++;
            $display("FAIL %s word %0d actual %h expected %h", tag, a, csr_rdata, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(3'd0, m_target, tag);
        chk(3'd1, m_good, tag);
        chk(3'd2, m_bad, tag);
        chk(3'd3, m_bytes[31:0], tag);
        chk(3'd4, m_bytes[63:32], tag);
        chk(3'd5, m_cyc[31:0], tag);
        chk(3'd6, m_cyc[63:32], tag);
        chk(3'd7, {29'd0, m_done, 2'b00}, tag);
    endtask

    initial begin
        #(4 * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk_all("R10 R1 reset state");

        idle(3);
        chk_all("R6 R5 idle before first start");

        wr_reg(3'd0, 32'd10);
        chk_all("R1 target write");

        // sweep of lengths, empty values and error flags
        for (int len = 1; len <= 3; len++) begin
            for (int em = 0; em < 8; em++) begin
                send_pkt(len, 3'(em), (em % 3) == 0);
                idle((em % 3) + 1);
                chk_all("R2 R3 R4 R5 R6 R7 sweep");
            end
        end

        // read-only words ignore writes
        for (int a = 1; a <= 6; a++) wr_reg(3'(a), 32'hDEAD_BEEF);
        wr_reg(3'd7, 32'hFFFF_FFFE);
        chk_all("R9 read-only writes");

        // clear coinciding with a complete single-beat packet
        step(1'b1, 1'b1, 1'b1, 3'd2, 1'b0, 1'b1, 3'd7, 32'h0000_0001);
        chk_all("R8 clear with beat");

        // single-beat packet reaching a target of one
        wr_reg(3'd0, 32'd1);
        idle(2);
        chk_all("R6 no start yet");
        step(1'b1, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 32'h0);
        chk_all("R6 R7 one-beat completion");
        idle(4);
        send_pkt(2, 3'd1, 1'b1);
        chk_all("R7 R6 counting after done, cycles frozen");

        // target not reached
        wr_reg(3'd7, 32'd1);
        wr_reg(3'd0, 32'd3);
        idle(1);
        send_pkt(3, 3'd7, 1'b0);
        idle(2);
        send_pkt(1, 3'd0, 1'b1);
        idle(3);
        chk_all("R7 R6 target not reached");
        send_pkt(2, 3'd4, 1'b0);
        idle(2);
        chk_all("R7 R2 target reached");

        finish_run();
    end

endmodule